// File: doc/BRIEF.md
# Translation Table Maintenance Register Unit

This unit holds the four software-visible registers that a kernel uses to fill, inspect and search a fully associative address translation table: a tag register (virtual page number and current address-space id), a data register (physical frame number plus attribute flags), an index register, and a free-running replacement counter. Software reads and writes these registers through a small port addressed by register number. It starts table operations with a one-hot command input. The commands are probe, read-at-index, write-at-index and write-at-counter.

The table storage lives in a neighbouring block. This unit drives the table's index, write enable and write data, and it always presents the tag register as the search key. It takes back the entry read at the driven index, together with the table's match result and matching index. When a translation fault occurs, a capture strobe loads the faulting page number into the tag register.

Top module: `tlbm_unit`

## Requirements
- R1: After reset the tag, data and index registers read zero and the counter reads 63. Register numbers are 0 for tag, 1 for data, 2 for index and 3 for counter. The counter value reads in bits 13:8 and all other bits read zero.
- R2: A software write lands on the next clock. The tag keeps bits 31:6 (page number 31:12, id 11:6), the data keeps bits 31:8 (frame 31:12, no-cache 11, writable 10, valid 9, global 8), and the index keeps bit 31 (fail flag) and bits 13:8 (entry number). Every other bit reads zero.
- R3: The counter steps down by one on every clock after reset. It goes from 8 directly to 63, so it never names entries 0 to 7.
- R4: Software writes to register number 3 have no effect on the counter.
- R5: A probe (command bit 0) whose search key hits loads the index register with the matching entry in bits 13:8 and clears the fail flag. This happens on the next clock.
- R6: A probe that misses sets bit 31 of the index register and leaves its entry field unchanged.
- R7: A read command (command bit 1) drives the index field to the table. On the next clock it loads the tag and data registers from the returned entry, masked as in R2.
- R8: A write-indexed command (command bit 2) raises the table write enable in the same cycle. It drives the index field as the table index, with the tag and data registers as write data.
- R9: A write-at-counter command (command bit 3) raises the write enable and drives the counter's current value as the table index. That value is always 8 or more.
- R10: The capture strobe replaces only the tag's page number on the next clock and leaves the id unchanged. If a software tag write happens in the same cycle, the id comes from that write.
- R11: A read command overrides both the capture strobe and software writes to the tag and data. A probe overrides a software write to the index.
- R12: A command word with zero or more than one bit set does nothing: no table write, and no register change from the command.
- R13: The table search key and write data always equal the current tag and data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 2 | Register number for read and write |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Contents of the selected register |
| cmd | input | 4 | One-hot command: probe, read, write-indexed, write-at-counter |
| cap_strobe | input | 1 | Fault capture strobe |
| cap_vpn | input | 20 | Faulting virtual page number |
| tbl_idx | output | 6 | Table entry index |
| tbl_we | output | 1 | Table write enable |
| tbl_key_hi | output | 32 | Search key and tag write data |
| tbl_wr_lo | output | 32 | Data-half write data |
| tbl_rd_hi | input | 32 | Tag half of entry at tbl_idx |
| tbl_rd_lo | input | 32 | Data half of entry at tbl_idx |
| probe_hit | input | 1 | Table found a match for the key |
| probe_idx | input | 6 | Lowest matching entry |

## Verification
Several functions can fall in the same cycle. A fault capture can arrive with a software tag write or with a read command, and a probe can arrive with a software write to the index. The bench provokes these by drawing the capture strobe, the register write and the command independently on every cycle, and also by a directed cycle that applies all three to the tag at once. It judges the result against a behavioural model that applies the priority in R10 and R11: the read wins, the capture keeps the written id, and the probe result replaces the written index.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  localparam int VPN_W    = 20;
  localparam int VPN_LSB  = 12;
  localparam int PID_W    = 6;
  localparam int PID_LSB  = 6;
  localparam int IDX_LSB  = 8;
  localparam int FAIL_BIT = 31;
  localparam int CMD_W    = 4;

  // attribute flag positions in the data half
  localparam int NOCACHE_BIT  = 11;
  localparam int WRITABLE_BIT = 10;
  localparam int VALID_BIT    = 9;
  localparam int GLOBAL_BIT   = 8;

  localparam logic [31:0] TAG_MASK  = 32'hFFFF_FFC0;
  localparam logic [31:0] DATA_MASK = 32'hFFFF_FF00;
  localparam logic [31:0] FAIL_FLAG = 32'h8000_0000;

  // command bit positions
  localparam int CMD_PROBE = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRIDX = 2;
  localparam int CMD_WRRND = 3;

  typedef enum logic [1:0] {
    SEL_TAG   = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_INDEX = 2'd2,
    SEL_RAND  = 2'd3
  } sel_e;

  typedef struct packed {
    logic probe;
    logic rd;
    logic wri;
    logic wrr;
  } cmd_t;

endpackage

// File: rtl/tlbm_rst_sync.sv
module tlbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_i = s2_q;

endmodule

// File: rtl/tlbm_rand_ctr.sv
module tlbm_rand_ctr #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_i,
  output logic [IDX_W-1:0] rand_q
);

  localparam logic [IDX_W-1:0] LAST_V  = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FLOOR_V = IDX_W'(WIRED);

  logic [IDX_W-1:0] rand_d;
  logic             rand_en;

  always_comb begin
    rand_en = 1'b1;
    if (rand_q == FLOOR_V) begin
      rand_d = LAST_V;
    end else begin
      rand_d = rand_q - IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rand_q <= LAST_V;
    end else if (rand_en) begin
      rand_q <= rand_d;
    end
  end

endmodule

// File: rtl/tlbm_cmd_dec.sv
module tlbm_cmd_dec
  import tlbm_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_t             act
);

  logic single;

  always_comb begin
    single    = (cmd != '0) && ((cmd & (cmd - CMD_W'(1))) == '0);
    act.probe = single & cmd[CMD_PROBE];
    act.rd    = single & cmd[CMD_READ];
    act.wri   = single & cmd[CMD_WRIDX];
    act.wrr   = single & cmd[CMD_WRRND];
  end

endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
  import tlbm_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             sw_wr,
  input  sel_e             sw_sel,
  input  logic [31:0]      sw_wdata,
  input  cmd_t             act,
  input  logic             capture,
  input  logic [VPN_W-1:0] cap_vpn,
  input  logic             probe_hit,
  input  logic [IDX_W-1:0] probe_idx,
  input  logic [31:0]      rd_hi,
  input  logic [31:0]      rd_lo,
  output logic [31:0]      tag_q,
  output logic [31:0]      data_q,
  output logic [31:0]      index_q
);

  localparam logic [31:0] IDX_MASK =
    FAIL_FLAG | (((32'h1 << IDX_W) - 32'h1) << IDX_LSB);

  logic [31:0] tag_d, data_d, index_d;
  logic        tag_en, data_en, index_en;

  // tag: read command first, then software write with capture merged on top
  always_comb begin
    tag_d  = tag_q;
    tag_en = 1'b0;
    if (act.rd) begin
      tag_d  = rd_hi & TAG_MASK;
      tag_en = 1'b1;
    end else begin
      if (sw_wr && (sw_sel == SEL_TAG)) begin
        tag_d  = sw_wdata & TAG_MASK;
        tag_en = 1'b1;
      end
      if (capture) begin
        tag_d[VPN_LSB +: VPN_W] = cap_vpn;
        tag_en                  = 1'b1;
      end
    end
  end

  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    if (act.rd) begin
      data_d  = rd_lo & DATA_MASK;
      data_en = 1'b1;
    end else if (sw_wr && (sw_sel == SEL_DATA)) begin
      data_d  = sw_wdata & DATA_MASK;
      data_en = 1'b1;
    end
  end

  always_comb begin
    index_d  = index_q;
    index_en = 1'b0;
    if (act.probe) begin
      index_en = 1'b1;
      if (probe_hit) begin
        index_d                    = '0;
        index_d[IDX_LSB +: IDX_W]  = probe_idx;
      end else begin
        index_d = index_q | FAIL_FLAG;
      end
    end else if (sw_wr && (sw_sel == SEL_INDEX)) begin
      index_d  = sw_wdata & IDX_MASK;
      index_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      index_q <= '0;
    end else if (index_en) begin
      index_q <= index_d;
    end
  end

endmodule

// File: rtl/tlbm_unit.sv
module tlbm_unit
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              cap_strobe,
  input  logic [VPN_W-1:0]  cap_vpn,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_we,
  output logic [31:0]       tbl_key_hi,
  output logic [31:0]       tbl_wr_lo,
  input  logic [31:0]       tbl_rd_hi,
  input  logic [31:0]       tbl_rd_lo,
  input  logic              probe_hit,
  input  logic [IDX_W-1:0]  probe_idx
);

  logic             rst_i;
  logic [IDX_W-1:0] rand_q;
  cmd_t             act;
  logic [31:0]      tag_q, data_q, index_q;
  sel_e             sel;

  assign sel = sel_e'(reg_sel);

  tlbm_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_i (rst_i)
  );

  tlbm_rand_ctr #(
    .ENTRIES (ENTRIES),
    .WIRED   (WIRED)
  ) u_rand (
    .clk    (clk),
    .rst_i  (rst_i),
    .rand_q (rand_q)
  );

  tlbm_cmd_dec u_dec (
    .cmd (cmd),
    .act (act)
  );

  tlbm_regs #(
    .IDX_W (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_i     (rst_i),
    .sw_wr     (reg_wr),
    .sw_sel    (sel),
    .sw_wdata  (reg_wdata),
    .act       (act),
    .capture   (cap_strobe),
    .cap_vpn   (cap_vpn),
    .probe_hit (probe_hit),
    .probe_idx (probe_idx),
    .rd_hi     (tbl_rd_hi),
    .rd_lo     (tbl_rd_lo),
    .tag_q     (tag_q),
    .data_q    (data_q),
    .index_q   (index_q)
  );

  // table port
  always_comb begin
    tbl_we     = act.wri | act.wrr;
    tbl_key_hi = tag_q;
    tbl_wr_lo  = data_q;
    if (act.wrr) begin
      tbl_idx = rand_q;
    end else begin
      tbl_idx = index_q[IDX_LSB +: IDX_W];
    end
  end

  // software read mux
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_TAG:   reg_rdata = tag_q;
      SEL_DATA:  reg_rdata = data_q;
      SEL_INDEX: reg_rdata = index_q;
      SEL_RAND:  reg_rdata[IDX_LSB +: IDX_W] = rand_q;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tlbm_unit_chk.sv
module tlbm_unit_chk #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_i,
  input logic [3:0]       cmd,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic             cap_strobe,
  input logic             tbl_we,
  input logic [IDX_W-1:0] tbl_idx,
  input logic [IDX_W-1:0] rand_q,
  input logic [31:0]      tag_q,
  input logic [31:0]      index_q
);

  localparam logic [IDX_W-1:0] LAST_V  = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FLOOR_V = IDX_W'(WIRED);
  localparam logic [31:0] IDX_KEEP =
    32'h8000_0000 | (((32'h1 << IDX_W) - 32'h1) << 8);

  // R3: counter stays in the replaceable range
  p_rand_range_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (rand_q >= FLOOR_V) && (rand_q <= LAST_V));

  // R3: counter steps every clock with wrap from floor to top
  p_rand_step_r3: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (rand_q == (($past(rand_q) == FLOOR_V) ? LAST_V
                                                     : $past(rand_q) - IDX_W'(1))));

  // R4: a software write to the counter does not disturb its step
  p_rand_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_wr && (reg_sel == 2'd3)) |=> (rand_q != $past(rand_q)));

  // R12: table writes only on a single-bit write command
  p_we_single_r12: assert property (@(posedge clk) disable iff (!rst_i)
    tbl_we |-> ($onehot(cmd) && (cmd[2] || cmd[3])));

  // R9: write-at-counter never targets the protected entries
  p_wrr_range_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd == 4'b1000) |-> (tbl_idx >= FLOOR_V));

  // R10: capture without read or tag write keeps the id field
  p_cap_pid_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (cap_strobe && !(reg_wr && (reg_sel == 2'd0)) && (cmd != 4'b0010))
      |=> (tag_q[11:6] == $past(tag_q[11:6])));

  // R2: unused index bits stay clear
  p_idx_clean_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (index_q & ~IDX_KEEP) == 32'h0);

endmodule

bind tlbm_unit tlbm_unit_chk #(
  .ENTRIES (ENTRIES),
  .WIRED   (WIRED)
) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .cmd        (cmd),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .cap_strobe (cap_strobe),
  .tbl_we     (tbl_we),
  .tbl_idx    (tbl_idx),
  .rand_q     (rand_q),
  .tag_q      (tag_q),
  .index_q    (index_q)
);

// File: tb/tlbm_unit_test.sv
module tlbm_unit_test;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  cmd;
  logic        cap_strobe;
  logic [19:0] cap_vpn;
  logic [5:0]  tbl_idx;
  logic        tbl_we;
  logic [31:0] tbl_key_hi, tbl_wr_lo, tbl_rd_hi, tbl_rd_lo;
  logic        probe_hit;
  logic [5:0]  probe_idx;

  logic [31:0] t_hi [N];
  logic [31:0] t_lo [N];

  logic [31:0] m_tag, m_data, m_index;
  int          m_rand;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #4 clk = ~clk;

  tlbm_unit uut (
    .clk (clk), .rst_n (rst_n), .reg_sel (reg_sel), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cmd (cmd),
    .cap_strobe (cap_strobe), .cap_vpn (cap_vpn), .tbl_idx (tbl_idx),
    .tbl_we (tbl_we), .tbl_key_hi (tbl_key_hi), .tbl_wr_lo (tbl_wr_lo),
    .tbl_rd_hi (tbl_rd_hi), .tbl_rd_lo (tbl_rd_lo),
    .probe_hit (probe_hit), .probe_idx (probe_idx)
  );

  // behavioural table: read at index, search lowest matching entry
  assign tbl_rd_hi = t_hi[tbl_idx];
  assign tbl_rd_lo = t_lo[tbl_idx];

  always_comb begin
    probe_hit = 1'b0;
    probe_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (t_hi[i][31:12] == tbl_key_hi[31:12] &&
          (t_hi[i][11:6] == tbl_key_hi[11:6] || t_lo[i][8])) begin
        probe_hit = 1'b1;
        probe_idx = 6'(i);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int model_search(input logic [31:0] key);
    for (int i = 0; i < N; i++) begin
      if (t_hi[i][31:12] == key[31:12] &&
          (t_hi[i][11:6] == key[11:6] || t_lo[i][8])) return i;
    end
    return -1;
  endfunction

  // one clock: drive at negedge, compare before the edge, advance the model
  task automatic step(input logic [1:0] sel, input logic wr, input logic [31:0] wd,
                      input logic [3:0] c, input logic cap, input logic [19:0] cv,
                      input string lbl);
    logic [31:0] exp_rd, n_tag, n_data, n_index;
    int          idxf, hit, nb;
    bit          single, pr, rd, wi, wrr;
    string       l;
    reg_sel = sel; reg_wr = wr; reg_wdata = wd; cmd = c;
    cap_strobe = cap; cap_vpn = cv;
    #1;
    case (sel)
      2'd0: begin exp_rd = m_tag;   l = "R10 tag read";  end
      2'd1: begin exp_rd = m_data;  l = "R7 data read";  end
      2'd2: begin exp_rd = m_index; l = "R5 index read"; end
      default: begin exp_rd = 32'(m_rand) << 8; l = "R3 counter read"; end
    endcase
    if (lbl != "") l = lbl;
    chk(l, reg_rdata, exp_rd);
    chk("R13 key", tbl_key_hi, m_tag);
    chk("R13 write data", tbl_wr_lo, m_data);
    nb = 0;
    for (int b = 0; b < 4; b++) if (c[b]) nb++;
    single = (nb == 1);
    pr = single && c[0]; rd = single && c[1]; wi = single && c[2]; wrr = single && c[3];
    idxf = int'(m_index[13:8]);
    chk("R12 write enable", 32'(tbl_we), 32'(wi || wrr));
    if (wrr) chk("R9 counter index", 32'(tbl_idx), 32'(m_rand));
    else if (wi || rd) chk("R8 indexed entry", 32'(tbl_idx), 32'(idxf));
    // next state
    n_tag = m_tag; n_data = m_data; n_index = m_index;
    if (rd) begin
      n_tag  = t_hi[idxf] & 32'hFFFF_FFC0;
      n_data = t_lo[idxf] & 32'hFFFF_FF00;
    end else begin
      if (wr && sel == 2'd0) n_tag = wd & 32'hFFFF_FFC0;
      if (cap) n_tag[31:12] = cv;
      if (wr && sel == 2'd1) n_data = wd & 32'hFFFF_FF00;
    end
    if (pr) begin
      hit = model_search(m_tag);
      if (hit >= 0) n_index = 32'(hit) << 8;
      else          n_index = m_index | 32'h8000_0000;
    end else if (wr && sel == 2'd2) begin
      n_index = wd & 32'h8000_3F00;
    end
    @(posedge clk);
    #1;
    if (wi) begin t_hi[idxf] = m_tag; t_lo[idxf] = m_data; end
    if (wrr) begin t_hi[m_rand] = m_tag; t_lo[m_rand] = m_data; end
    m_tag = n_tag; m_data = n_data; m_index = n_index;
    m_rand = (m_rand == 8) ? 63 : m_rand - 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd;
    logic [3:0]  c;
    int          r;
    for (int i = 0; i < N; i++) begin t_hi[i] = '0; t_lo[i] = '0; end
    rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_wdata = '0; cmd = '0;
    cap_strobe = 1'b0; cap_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    m_tag = '0; m_data = '0; m_index = '0; m_rand = 63;

    // R1: reset state of all four registers
    step(2'd3, 0, 0, 0, 0, 0, "R1 counter after reset");
    step(2'd0, 0, 0, 0, 0, 0, "R1 tag after reset");
    step(2'd1, 0, 0, 0, 0, 0, "R1 data after reset");
    step(2'd2, 0, 0, 0, 0, 0, "R1 index after reset");
    // R2: write masks
    step(2'd0, 1, 32'hFFFF_FFFF, 0, 0, 0, "");
    step(2'd0, 0, 0, 0, 0, 0, "R2 tag mask");
    step(2'd1, 1, 32'hFFFF_FFFF, 0, 0, 0, "");
    step(2'd1, 0, 0, 0, 0, 0, "R2 data mask");
    step(2'd2, 1, 32'hFFFF_FFFF, 0, 0, 0, "");
    step(2'd2, 0, 0, 0, 0, 0, "R2 index mask");
    // R4: counter write ignored
    step(2'd3, 1, 32'h0000_0500, 0, 0, 0, "");
    step(2'd3, 0, 0, 0, 0, 0, "R4 counter after write");
    // R8 / R9: fill entry 10 and a counter entry
    step(2'd0, 1, {20'h00005, 6'd3, 6'd0}, 0, 0, 0, "");
    step(2'd1, 1, {20'h12345, 12'h600}, 0, 0, 0, "");
    step(2'd2, 1, 32'h0000_0A00, 0, 0, 0, "");
    step(2'd2, 0, 0, 4'b0100, 0, 0, "R8 index before write");
    step(2'd0, 0, 0, 4'b1000, 0, 0, "R9 tag during counter write");
    // R5 hit, R6 miss
    step(2'd0, 0, 0, 4'b0001, 0, 0, "");
    step(2'd2, 0, 0, 0, 0, 0, "R5 probe hit index");
    step(2'd0, 1, {20'h00005, 6'd4, 6'd0}, 0, 0, 0, "");
    step(2'd0, 0, 0, 4'b0001, 0, 0, "");
    step(2'd2, 0, 0, 0, 0, 0, "R6 probe miss index");
    // R7 read back
    step(2'd0, 1, 32'h0, 0, 0, 0, "");
    step(2'd1, 0, 0, 4'b0010, 0, 0, "");
    step(2'd0, 0, 0, 0, 0, 0, "R7 tag after read");
    step(2'd1, 0, 0, 0, 0, 0, "R7 data after read");
    // R10 capture alone and merged with a write
    step(2'd0, 0, 0, 0, 1, 20'hABCDE, "");
    step(2'd0, 0, 0, 0, 0, 0, "R10 capture keeps id");
    step(2'd0, 1, {20'h11111, 6'd9, 6'd0}, 0, 1, 20'h22222, "");
    step(2'd0, 0, 0, 0, 0, 0, "R10 capture merged id");
    // R11 collisions
    step(2'd0, 1, 32'hDEAD_BEEF, 4'b0010, 1, 20'h33333, "");
    step(2'd0, 0, 0, 0, 0, 0, "R11 read beats capture and write");
    step(2'd2, 1, 32'h0000_2000, 4'b0001, 0, 0, "");
    step(2'd2, 0, 0, 0, 0, 0, "R11 probe beats index write");
    // R12 multi-bit command
    step(2'd0, 0, 0, 4'b0110, 0, 0, "");
    step(2'd0, 0, 0, 0, 0, 0, "R12 tag after multi-bit command");
    step(2'd2, 0, 0, 4'b1001, 0, 0, "");
    step(2'd2, 0, 0, 0, 0, 0, "R12 index after multi-bit command");

    // mixed traffic with frequent same-cycle events
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] s;
      s = 2'($urandom % 4);
      case (s)
        2'd0: wd = {20'($urandom % 4), 6'($urandom % 2), 6'($urandom)};
        2'd2: wd = $urandom;
        default: wd = $urandom;
      endcase
      r = $urandom % 10;
      if (r < 5)       c = 4'b0000;
      else if (r < 9)  c = 4'b0001 << ($urandom % 4);
      else             c = 4'($urandom);
      step(s, ($urandom % 3) == 0, wd, c, ($urandom % 8) == 0,
           20'($urandom % 4), "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule